// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Status Queue

This block turns an asynchronous serial line into characters for a CPU. The line is sampled on a 16x oversampling enable supplied from outside. The block checks the start bit, collects 5 to 8 data bits with the least significant bit first, reads an optional parity or address/data bit, and checks the stop bit. The result, with its own parity, framing and break flags, goes through a one-character shift stage into a three-entry queue. The CPU reads the head of the queue and its flags, and a one-cycle `pop` removes that entry.

Status outputs show whether characters are waiting, whether the queue is full, and whether data was lost. Error flags follow either the head entry or an accumulated history that `err_clr` resets. The interrupt line follows either the ready flag or the full flag. A flow-control output asks the link partner to stop sending when a new start bit arrives while the queue is full.

Top module: `uart_rx_status`

## Requirements
- R1: After synchronous reset, `rdy`, `full`, `ovr`, `irq`, `rts_negate`, `par_err`, `frm_err` and `brk` are all 0.
- R2: `cfg_len` selects the data width as 5 + `cfg_len` bits (0 gives 5, 3 gives 8). Bits arrive least significant first, and unused upper bits of `rd_data` read as 0.
- R3: `cfg_par` codes 000 and 001 expect a bit that makes the count of ones even or odd, and 010 and 011 expect a fixed 0 or 1. A mismatch sets the entry's parity flag. Codes 100 and 101 mean no parity bit is on the line.
- R4: With `cfg_par` 110 or 111 (multidrop), the bit after the data is received, and its value is stored in the entry's parity flag in place of a check.
- R5: A start is accepted only if the line is still low at the eighth 16x tick after the falling edge is seen. Otherwise no character is produced.
- R6: A stop bit sampled low sets the entry's framing flag.
- R7: `rdy` is 1 while at least one entry is queued, and `full` is 1 while three entries are queued. Entries leave in arrival order.
- R8: When a character completes while the queue is full and the shift stage is already occupied, that character is lost and `ovr` sets. `ovr` stays set until `err_clr`.
- R9: With `cfg_err_block` = 0, `par_err`/`frm_err`/`brk` show the head entry's flags, or 0 when the queue is empty. With `cfg_err_block` = 1, they show the OR of the flags of every entry queued since the last `err_clr`.
- R10: A frame whose data bits, parity bit (if present) and stop bit are all 0 is stored once, with data 0 and both the break and framing flags set. No new start is accepted until the line has been high for 8 consecutive ticks.
- R11: `irq` follows `full` when `cfg_irq_full` = 1, and `rdy` otherwise.
- R12: When `cfg_rts_en` = 1, a start edge seen while the queue is full sets `rts_negate`. It clears once the queue is no longer full.
- R13: A `pop` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial input line, idles high |
| cfg_len | input | 2 | Data width select |
| cfg_par | input | 3 | Parity / multidrop mode |
| cfg_err_block | input | 1 | 1 = accumulated error status |
| cfg_irq_full | input | 1 | 1 = interrupt from full flag |
| cfg_rts_en | input | 1 | Enable start-bit flow control |
| pop | input | 1 | Remove the head entry |
| err_clr | input | 1 | Clear overrun and accumulated flags |
| rd_data | output | 8 | Head entry data |
| rdy | output | 1 | At least one entry queued |
| full | output | 1 | Three entries queued |
| ovr | output | 1 | Character lost |
| par_err | output | 1 | Parity flag, or address/data bit in multidrop |
| frm_err | output | 1 | Framing flag |
| brk | output | 1 | Break flag |
| irq | output | 1 | Interrupt request |
| rts_negate | output | 1 | Request to deassert RTS |

## Verification
The assertions assume that the configuration inputs do not change while a frame is being received, and that `tick16` is a single-cycle enable. The stimulus changes configuration only while the line is idle. It drives `tick16` every second cycle, so one bit lasts 32 clocks. Bits are held for whole bit times, except that a low stop bit is shortened to 24 clocks. That avoids an accidental start being confirmed right after a framing error. `pop` and `err_clr` are one-cycle pulses, and the queue assertions rely on the top never passing a pop to an empty queue.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 3;
    localparam int OSR        = 16;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_entry_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP,
        FS_BRK
    } fsm_t;

    function automatic logic [3:0] char_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic has_parity(input logic [2:0] mode);
        return mode[2:1] != 2'b10;
    endfunction

    function automatic logic is_multidrop(input logic [2:0] mode);
        return mode[2:1] == 2'b11;
    endfunction

    // Value the parity bit should carry for a checked mode.
    function automatic logic want_parity(input logic [2:0] mode,
                                         input logic [DATA_W-1:0] d);
        logic r;
        case (mode[1:0])
            2'b00:   r = ^d;
            2'b01:   r = ~^d;
            2'b10:   r = 1'b0;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OSR_P = OSR
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [2:0] cfg_par,
    output logic       start_seen,
    output logic       done,
    output rx_entry_t  ch
);

    localparam int CNT_W = $clog2(OSR_P);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR_P / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR_P - 1);

    logic [1:0]        sync_q;
    logic              rx;
    fsm_t              state;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              brk_now;
    logic              perr_now;

    assign rx = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    assign brk_now  = !rx && (shreg == '0) && (!has_parity(cfg_par) || !pbit);
    assign perr_now = is_multidrop(cfg_par) ? pbit :
                      has_parity(cfg_par)   ? (pbit != want_parity(cfg_par, shreg)) :
                                              1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= FS_IDLE;
            cnt        <= '0;
            bidx       <= '0;
            shreg      <= '0;
            pbit       <= 1'b0;
            done       <= 1'b0;
            start_seen <= 1'b0;
            ch         <= '0;
        end else begin
            done       <= 1'b0;
            start_seen <= 1'b0;
            if (tick) begin
                case (state)
                    FS_IDLE: begin
                        if (!rx) begin
                            state      <= FS_START;
                            cnt        <= '0;
                            start_seen <= 1'b1;
                        end
                    end
                    FS_START: begin
                        if (cnt == MID_C) begin
                            state <= rx ? FS_IDLE : FS_DATA;
                            cnt   <= '0;
                            bidx  <= '0;
                            shreg <= '0;
                            pbit  <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_DATA: begin
                        if (cnt == LAST_C) begin
                            cnt         <= '0;
                            shreg[bidx] <= rx;
                            bidx        <= bidx + 1'b1;
                            if ({1'b0, bidx} == char_bits(cfg_len) - 4'd1)
                                state <= has_parity(cfg_par) ? FS_PAR : FS_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_PAR: begin
                        if (cnt == LAST_C) begin
                            cnt   <= '0;
                            pbit  <= rx;
                            state <= FS_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_STOP: begin
                        if (cnt == LAST_C) begin
                            cnt     <= '0;
                            done    <= 1'b1;
                            ch.data <= shreg;
                            ch.perr <= perr_now;
                            ch.ferr <= !rx;
                            ch.brk  <= brk_now;
                            state   <= brk_now ? FS_BRK : FS_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_BRK: begin
                        if (rx) begin
                            if (cnt == MID_C) state <= FS_IDLE;
                            cnt <= cnt + 1'b1;
                        end else begin
                            cnt <= '0;
                        end
                    end
                    default: state <= FS_IDLE;
                endcase
            end
        end
    end

    // R2: one completed character per frame, never on back-to-back cycles
    assert_single_done_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: while waiting out a break, no start edge is reported
    assert_brk_no_start_R10: assert property (@(posedge clk) disable iff (rst)
        (state == FS_BRK) |=> !start_seen);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t push_data,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == DEPTH_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: a push only lands in a full queue together with a pop
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (count < DEPTH_C));

    // R13: the queue never sees a pop while empty
    assert_no_underflow_R13: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [2:0] cfg_par,
    input  logic       cfg_err_block,
    input  logic       cfg_irq_full,
    input  logic       cfg_rts_en,
    input  logic       pop,
    input  logic       err_clr,
    output logic [7:0] rd_data,
    output logic       rdy,
    output logic       full,
    output logic       ovr,
    output logic       par_err,
    output logic       frm_err,
    output logic       brk,
    output logic       irq,
    output logic       rts_negate
);

    logic      start_seen;
    logic      done;
    rx_entry_t new_ch;
    rx_entry_t head;
    logic      q_empty;
    logic      q_full;

    rx_entry_t hold_q;
    logic      hold_v;
    logic      push;
    rx_entry_t push_data;
    logic      pop_en;
    logic      space;

    logic      acc_perr, acc_ferr, acc_brk;
    logic      ovr_q;
    logic      rts_q;

    uart_rx_framer #(.OSR_P(OSR)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick16),
        .rxd        (rxd),
        .cfg_len    (cfg_len),
        .cfg_par    (cfg_par),
        .start_seen (start_seen),
        .done       (done),
        .ch         (new_ch)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (pop_en),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign pop_en = pop && !q_empty;
    assign space  = !q_full || pop_en;

    // The shift stage empties into the queue first; a new character goes
    // straight in only when the stage is empty.
    always_comb begin
        push      = 1'b0;
        push_data = new_ch;
        if (hold_v) begin
            push      = space;
            push_data = hold_q;
        end else if (done) begin
            push      = space;
            push_data = new_ch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            hold_v <= 1'b0;
        end else if (hold_v) begin
            if (done && space) begin
                hold_q <= new_ch;
            end else if (space) begin
                hold_v <= 1'b0;
            end
        end else if (done && !space) begin
            hold_q <= new_ch;
            hold_v <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q    <= 1'b0;
            acc_perr <= 1'b0;
            acc_ferr <= 1'b0;
            acc_brk  <= 1'b0;
        end else begin
            if (err_clr) begin
                ovr_q    <= 1'b0;
                acc_perr <= 1'b0;
                acc_ferr <= 1'b0;
                acc_brk  <= 1'b0;
            end
            if (hold_v && done && !space) ovr_q <= 1'b1;
            if (push) begin
                if (push_data.perr) acc_perr <= 1'b1;
                if (push_data.ferr) acc_ferr <= 1'b1;
                if (push_data.brk)  acc_brk  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                   rts_q <= 1'b0;
        else if (start_seen && cfg_rts_en && q_full) rts_q <= 1'b1;
        else if (!q_full)                          rts_q <= 1'b0;
    end

    assign rd_data    = head.data;
    assign rdy        = !q_empty;
    assign full       = q_full;
    assign ovr        = ovr_q;
    assign par_err    = cfg_err_block ? acc_perr : (rdy && head.perr);
    assign frm_err    = cfg_err_block ? acc_ferr : (rdy && head.ferr);
    assign brk        = cfg_err_block ? acc_brk  : (rdy && head.brk);
    assign irq        = cfg_irq_full ? q_full : !q_empty;
    assign rts_negate = rts_q;

    // R7: a full queue is never reported as empty
    assert_full_rdy_R7: assert property (@(posedge clk) disable iff (rst)
        full |-> rdy);

    // R8: lost-data flag holds until cleared
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovr && !err_clr) |=> ovr);

    // R9: character mode reports nothing with an empty queue
    assert_char_mode_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_err_block && !rdy) |-> !(par_err || frm_err || brk));

    // R12: flow-control request rises only from a full queue with control on
    assert_rts_cause_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_negate) |-> ($past(full) && $past(cfg_rts_en)));

endmodule

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick16;
    logic       rxd;
    logic [1:0] cfg_len;
    logic [2:0] cfg_par;
    logic       cfg_err_block;
    logic       cfg_irq_full;
    logic       cfg_rts_en;
    logic       pop;
    logic       err_clr;
    logic [7:0] rd_data;
    logic       rdy, full, ovr, par_err, frm_err, brk, irq, rts_negate;

    int nchk  = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    initial tick16 = 1'b0;
    always @(negedge clk) tick16 <= ~tick16;

    uart_rx_status u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_err_block(cfg_err_block),
        .cfg_irq_full(cfg_irq_full), .cfg_rts_en(cfg_rts_en),
        .pop(pop), .err_clr(err_clr), .rd_data(rd_data), .rdy(rdy),
        .full(full), .ovr(ovr), .par_err(par_err), .frm_err(frm_err),
        .brk(brk), .irq(irq), .rts_negate(rts_negate)
    );

    // {len[2], par[3], data[8], pbit, stop, exp_data[8], exp_perr}
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {2'd3, 3'b000, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0},
        {2'd3, 3'b000, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b1},
        {2'd3, 3'b001, 8'h01, 1'b0, 1'b1, 8'h01, 1'b0},
        {2'd3, 3'b001, 8'h01, 1'b1, 1'b1, 8'h01, 1'b1},
        {2'd0, 3'b100, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0},
        {2'd1, 3'b010, 8'h7F, 1'b0, 1'b1, 8'h3F, 1'b0},
        {2'd1, 3'b010, 8'h7F, 1'b1, 1'b1, 8'h3F, 1'b1},
        {2'd2, 3'b011, 8'h80, 1'b1, 1'b1, 8'h00, 1'b0},
        {2'd2, 3'b011, 8'h55, 1'b0, 1'b1, 8'h55, 1'b1},
        {2'd3, 3'b110, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1},
        {2'd3, 3'b111, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0},
        {2'd3, 3'b101, 8'h96, 1'b0, 1'b0, 8'h96, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line(input logic v, input int cycles);
        rxd = v;
        repeat (cycles) @(negedge clk);
    endtask

    // One bit = 16 ticks = 32 clocks. A low stop bit is cut to 24 clocks.
    task automatic send(input logic [1:0] len, input logic [2:0] par,
                        input logic [7:0] d, input logic pb, input logic st);
        line(1'b0, 32);
        for (int i = 0; i < int'(len) + 5; i++) line(d[i], 32);
        if (par[2:1] != 2'b10) line(pb, 32);
        line(st, st ? 32 : 24);
        line(1'b1, 32);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic do_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rxd = 1'b1; cfg_len = 2'd3; cfg_par = 3'b100;
        cfg_err_block = 1'b0; cfg_irq_full = 1'b0; cfg_rts_en = 1'b0;
        pop = 1'b0; err_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 rdy", rdy, 0);
        chk("R1 full", full, 0);
        chk("R1 ovr", ovr, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rts_negate", rts_negate, 0);
        chk("R1 flags", {par_err, frm_err, brk}, 0);

        // R2 R3 R4 R6: format table
        for (int k = 0; k < NV; k++) begin
            cfg_len = VEC[k][23:22];
            cfg_par = VEC[k][21:19];
            send(VEC[k][23:22], VEC[k][21:19], VEC[k][18:11], VEC[k][10], VEC[k][9]);
            chk("R7 rdy after frame", rdy, 1);
            chk("R2 data", rd_data, VEC[k][8:1]);
            chk("R3 R4 parity slot", par_err, VEC[k][0]);
            chk("R6 framing", frm_err, !VEC[k][9]);
            chk("R10 no break", brk, 0);
            do_pop();
            chk("R7 empty after pop", rdy, 0);
        end
        do_clr();

        // R5: false start (low for 4 ticks only)
        cfg_len = 2'd3; cfg_par = 3'b100;
        line(1'b0, 8);
        line(1'b1, 32 * 12);
        chk("R5 false start ignored", rdy, 0);

        // R13: pop on empty, then normal operation still correct
        do_pop();
        chk("R13 empty pop rdy", rdy, 0);
        send(2'd3, 3'b100, 8'h77, 1'b0, 1'b1);
        chk("R13 data after empty pop", rd_data, 8'h77);
        chk("R13 single entry", full, 0);
        do_pop();
        chk("R13 drained", rdy, 0);

        // R8 R11 R7: overrun and interrupt source
        send(2'd3, 3'b100, 8'h11, 1'b0, 1'b1);
        send(2'd3, 3'b100, 8'h22, 1'b0, 1'b1);
        send(2'd3, 3'b100, 8'h33, 1'b0, 1'b1);
        chk("R7 full at three", full, 1);
        chk("R8 no overrun yet", ovr, 0);
        send(2'd3, 3'b100, 8'h44, 1'b0, 1'b1);
        send(2'd3, 3'b100, 8'h55, 1'b0, 1'b1);
        chk("R8 overrun set", ovr, 1);
        cfg_irq_full = 1'b1;
        #1;
        chk("R11 irq from full", irq, 1);
        chk("R7 order 1", rd_data, 8'h11);
        do_pop();
        chk("R7 order 2", rd_data, 8'h22);
        chk("R8 shift stage refilled queue", full, 1);
        do_pop();
        chk("R7 not full at two", full, 0);
        chk("R11 irq off with full source", irq, 0);
        cfg_irq_full = 1'b0;
        #1;
        chk("R11 irq from ready", irq, 1);
        chk("R7 order 3", rd_data, 8'h33);
        do_pop();
        chk("R8 held char kept", rd_data, 8'h44);
        do_pop();
        chk("R8 fifth char lost", rdy, 0);
        chk("R8 overrun sticky", ovr, 1);
        do_clr();
        chk("R8 overrun cleared", ovr, 0);

        // R12: flow control at start bit
        cfg_rts_en = 1'b1;
        send(2'd3, 3'b100, 8'hA1, 1'b0, 1'b1);
        send(2'd3, 3'b100, 8'hA2, 1'b0, 1'b1);
        send(2'd3, 3'b100, 8'hA3, 1'b0, 1'b1);
        chk("R12 idle while full", rts_negate, 0);
        send(2'd3, 3'b100, 8'hA4, 1'b0, 1'b1);
        chk("R12 set by start when full", rts_negate, 1);
        do_pop();
        chk("R12 still full", rts_negate, 1);
        do_pop();
        @(negedge clk);
        chk("R12 cleared when not full", rts_negate, 0);
        do_pop();
        do_pop();
        chk("R12 drained", rdy, 0);
        cfg_rts_en = 1'b0;

        // R9: error mode
        do_clr();
        cfg_par = 3'b000;
        cfg_err_block = 1'b1;
        send(2'd3, 3'b000, 8'hA5, 1'b1, 1'b1);
        send(2'd3, 3'b000, 8'h00, 1'b0, 1'b1);
        do_pop();
        chk("R9 block accumulates", par_err, 1);
        cfg_err_block = 1'b0;
        #1;
        chk("R9 char mode head only", par_err, 0);
        cfg_err_block = 1'b1;
        do_clr();
        chk("R9 block cleared", par_err, 0);
        cfg_err_block = 1'b0;
        do_pop();

        // R10: break, then inhibit until a half bit of high line
        cfg_par = 3'b100;
        line(1'b0, 32 * 12);
        line(1'b1, 8);
        line(1'b0, 32 * 4);
        line(1'b1, 32 * 2);
        chk("R10 break stored", rdy, 1);
        chk("R10 break flag", brk, 1);
        chk("R10 break framing", frm_err, 1);
        chk("R10 break data", rd_data, 0);
        do_pop();
        chk("R10 loads inhibited", rdy, 0);
        send(2'd3, 3'b100, 8'h5A, 1'b0, 1'b1);
        chk("R10 receive resumes", rd_data, 8'h5A);
        chk("R10 resumed no break", brk, 0);
        do_pop();

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule